// File: doc/BRIEF.md
# Shadowed Triggered Register Bank

This block is the register file that sits behind a serial control slave in a bias controller for three tunable-capacitor channels. The serial decoder hands it write and read strobes, a 5-bit register address and a data byte. The block returns read data and drives the committed per-channel codes, the per-channel fast-settle (turbo) flags, the glide configuration and the power mode to the analog side.

Writes to the configuration range (addresses 0 to 11) are first held in shadow copies. They reach the live copies only when a trigger fires. There are three triggers. Each channel picks its trigger through a 2-bit select field. Any trigger can be masked, and a masked trigger lets writes in its group go live at once. Two complete banks of channel codes exist, and a GPIO level chooses which bank drives the outputs. A change of that level also emits a one-cycle strobe that tells the glide logic to abandon a transition in progress. A soft reset and a power-mode reset return registers to their defaults. The soft reset spares the power/trigger register and the slave-ID nibble.

Top module: `shadow_trig_regbank`

## Requirements
- R1: After reset, code_out and turbo_out are 0, pwr_mode is 00 and operating is 1. Reads return 20h at address 0, 04h at address 10, 44h at address 11, 17h at address 31 and 00h at address 28. Read data appears on rdata the cycle after rd_en.
- R2: While the group of a register is unmasked, a write to any address 0..11 updates only its shadow copy. Live outputs do not change. A read of that address returns the shadow (last written) value.
- R3: A write to address 28 with bit g (g = 0..2) at 1 and bit 3+g at 0 in the same byte fires trigger g. The live copy of every register in group g then takes its shadow value, and the outputs show it the cycle after the write. Addresses 0, 1, 5, 9, 10 and 11 always belong to trigger 0. The code registers belong to the trigger of their channel.
- R4: Bits 5..3 of a write to address 28 are stored as masks for triggers 2..0. While the mask of group g is 1, a write to a register of that group goes to the shadow and the live copy together. A trigger bit written with its own mask bit at 1 does not fire.
- R5: Channel A takes its trigger select from address 9 bits 7:6, channel B from address 9 bits 3:2 and channel C from address 10 bits 7:6. The values 00, 01 and 10 select triggers 0, 1 and 2. A select of 11 joins no trigger and no mask, so that channel's codes never go live.
- R6: Addresses 2, 3 and 4 hold channels A, B and C for GPIO low, and addresses 6, 7 and 8 hold them for GPIO high. In each, bit 7 is the turbo flag and bits 6..0 are the code. Channel c is at code_out[7c+6:7c] and turbo_out[c], with A = 0. When the GPIO level differs from the level seen at the previous clock edge, the other bank drives the outputs after the next edge, and bank_swap is 1 for exactly that one cycle.
- R7: The live copy of address 1 drives step_delay from bits 7:3. Its bits 2, 1 and 0 drive glide_en[0] (A), glide_en[1] (B) and glide_en[2] (C).
- R8: A write to address 26 with bit 7 at 1 returns every register to its reset default, except the masks and power mode held at address 28 and the slave-ID nibble at address 31.
- R9: A write of 01 into bits 7:6 of address 0 or address 28 returns every register to its reset default at once, without staging.
- R10: A write to address 28 sets pwr_mode from bits 7:6 at once. When the live copy of address 0 is loaded, pwr_mode takes its bits 7:6 and operating takes its bit 5. A value of 11 leaves pwr_mode unchanged. An address-28 write takes priority over a simultaneous address-0 commit.
- R11: Addresses 29 and 30 always read 05h and 04h, and writes to them are ignored. Address 31 reads {2'b00, 2'b01, id} with a 4-bit writable id in bits 3:0.
- R12: Trigger bits never read back: a read of address 28 returns {pwr_mode, masks, 3'b000}. Addresses 12..25, 27 read 00h, and writes to them change no output and no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the serial decoder |
| rd_en | input | 1 | Read strobe from the serial decoder |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data byte |
| gpio | input | 1 | Bank-select level |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| code_out | output | 21 | Live 7-bit codes of channels A, B, C (A in the low bits) |
| turbo_out | output | 3 | Live turbo flags, bit 0 = A |
| glide_en | output | 3 | Glide enables, bit 0 = A |
| step_delay | output | 5 | Glide step delay code |
| pwr_mode | output | 2 | Power mode: 00 active, 10 low power |
| operating | output | 1 | 1 = operating, 0 = idle |
| bank_swap | output | 1 | One-cycle strobe on a GPIO level change |

## Verification
A stimulus table walks a sequence of staged writes and trigger writes. It shows that a write with no trigger leaves the outputs alone, that firing one trigger moves only the channels mapped to it, and that a remapped channel follows its new trigger and not the old one. The same table includes a trigger bit written with its own mask bit set, which must not fire, and a bypassed write under a stored mask, which must go live at once. Directed tests then set the second bank and toggle the GPIO level, apply the soft reset and both forms of the mode reset against registers they must spare or clear, and exercise the unused select code 11. Read-back covers the read-only identity bytes, the slave-ID nibble, self-clearing trigger bits and unimplemented addresses.

// File: rtl/shadow_trig_regbank.sv
module shadow_trig_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        gpio,
  output logic [7:0]  rdata,
  output logic [20:0] code_out,
  output logic [2:0]  turbo_out,
  output logic [2:0]  glide_en,
  output logic [4:0]  step_delay,
  output logic [1:0]  pwr_mode,
  output logic        operating,
  output logic        bank_swap
);
  localparam int NREG = 12;
  localparam int NCH  = 3;
  localparam int CW   = 7;

  logic [7:0] sh [NREG];
  logic [7:0] lv [NREG];
  logic [1:0] grp [NREG];
  logic [NREG-1:0] ld_byp, ld_fire;
  logic [2:0] mask, fire;
  logic [3:0] mask4, fire4;
  logic [3:0] usid;
  logic [6:0] status;
  logic       gpio_q;
  logic       we28, mode_rst, soft_rst, lv0_ld;
  logic [7:0] lv0_new;

  function automatic logic [7:0] dflt(int i);
    case (i)
      0:       return 8'h20;
      10:      return 8'h04;
      11:      return 8'h44;
      default: return 8'h00;
    endcase
  endfunction

  assign we28     = wr_en && addr == 5'd28;
  assign fire     = we28 ? (wdata[2:0] & ~wdata[5:3]) : 3'b000;
  assign mask4    = {1'b0, mask};
  assign fire4    = {1'b0, fire};
  assign mode_rst = wr_en && (addr == 5'd0 || addr == 5'd28) && wdata[7:6] == 2'b01;
  assign soft_rst = wr_en && addr == 5'd26 && wdata[7];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      grp[i] = 2'b00;
      if (i == 2 || i == 6)      grp[i] = lv[9][7:6];
      else if (i == 3 || i == 7) grp[i] = lv[9][3:2];
      else if (i == 4 || i == 8) grp[i] = lv[10][7:6];
      ld_byp[i]  = wr_en && addr == 5'(i) && mask4[grp[i]];
      ld_fire[i] = fire4[grp[i]];
    end
  end

  assign lv0_ld  = ld_byp[0] || ld_fire[0];
  assign lv0_new = ld_byp[0] ? wdata : sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        sh[i] <= dflt(i);
        lv[i] <= dflt(i);
      end
      mask     <= 3'b000;
      pwr_mode <= 2'b00;
      usid     <= 4'h7;
      status   <= 7'h00;
    end else if (mode_rst) begin
      for (int i = 0; i < NREG; i++) begin
        sh[i] <= dflt(i);
        lv[i] <= dflt(i);
      end
      mask     <= 3'b000;
      pwr_mode <= 2'b00;
      usid     <= 4'h7;
      status   <= 7'h00;
    end else if (soft_rst) begin
      for (int i = 0; i < NREG; i++) begin
        sh[i] <= dflt(i);
        lv[i] <= dflt(i);
      end
      status <= 7'h00;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && addr == 5'(i)) sh[i] <= wdata;
        if (ld_byp[i])       lv[i] <= wdata;
        else if (ld_fire[i]) lv[i] <= sh[i];
      end
      if (we28) begin
        mask <= wdata[5:3];
        if (wdata[7:6] != 2'b11) pwr_mode <= wdata[7:6];
      end else if (lv0_ld && lv0_new[7:6] != 2'b11) begin
        pwr_mode <= lv0_new[7:6];
      end
      if (wr_en && addr == 5'd26) status <= wdata[6:0];
      if (wr_en && addr == 5'd31) usid <= wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_q    <= 1'b0;
      bank_swap <= 1'b0;
    end else begin
      gpio_q    <= gpio;
      bank_swap <= gpio != gpio_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else if (rd_en) begin
      if (addr < 5'(NREG))  rdata <= sh[addr[3:0]];
      else case (addr)
        5'd26:   rdata <= {1'b0, status};
        5'd28:   rdata <= {pwr_mode, mask, 3'b000};
        5'd29:   rdata <= 8'h05;
        5'd30:   rdata <= 8'h04;
        5'd31:   rdata <= {4'b0001, usid};
        default: rdata <= 8'h00;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0] sel;
    assign sel = gpio_q ? lv[6+c] : lv[2+c];
    assign code_out[CW*c +: CW] = sel[CW-1:0];
    assign turbo_out[c]         = sel[7];
  end

  assign glide_en   = {lv[1][0], lv[1][1], lv[1][2]};
  assign step_delay = lv[1][7:3];
  assign operating  = lv[0][5];
endmodule

// File: rtl/shadow_trig_regbank_chk.sv
module shadow_trig_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [4:0]  addr,
  input logic [7:0]  wdata,
  input logic        gpio,
  input logic [7:0]  rdata,
  input logic [20:0] code_out,
  input logic [1:0]  pwr_mode,
  input logic        operating,
  input logic        bank_swap
);
  a_r6_swap_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio) |=> bank_swap);

  a_r2_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $past(gpio) == $past(gpio, 2)) |-> $stable(code_out));

  a_r10_mode_not_unused: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'b11);

  a_r11_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 5'd29) |=> rdata == 8'h05);

  a_r9_mode_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'd28 && wdata[7:6] == 2'b01) |=> (code_out == 21'd0 && pwr_mode == 2'b00 && operating));

  a_r12_unimpl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= 5'd12 && addr <= 5'd25) |=> rdata == 8'h00);
endmodule

bind shadow_trig_regbank shadow_trig_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .gpio(gpio), .rdata(rdata), .code_out(code_out),
  .pwr_mode(pwr_mode), .operating(operating), .bank_swap(bank_swap)
);

// File: tb/tb_shadow_trig_regbank.sv
module tb_shadow_trig_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, gpio = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [20:0] code_out;
  logic [2:0]  turbo_out, glide_en;
  logic [4:0]  step_delay;
  logic [1:0]  pwr_mode;
  logic        operating, bank_swap;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  shadow_trig_regbank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .gpio(gpio), .rdata(rdata), .code_out(code_out),
    .turbo_out(turbo_out), .glide_en(glide_en), .step_delay(step_delay),
    .pwr_mode(pwr_mode), .operating(operating), .bank_swap(bank_swap)
  );

  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {5'd2,  8'h15, 7'h00, 7'h00, 7'h00},
    {5'd3,  8'h22, 7'h00, 7'h00, 7'h00},
    {5'd28, 8'h01, 7'h00, 7'h22, 7'h15},
    {5'd9,  8'h04, 7'h00, 7'h22, 7'h15},
    {5'd28, 8'h01, 7'h00, 7'h22, 7'h15},
    {5'd3,  8'h33, 7'h00, 7'h22, 7'h15},
    {5'd28, 8'h01, 7'h00, 7'h22, 7'h15},
    {5'd28, 8'h02, 7'h00, 7'h33, 7'h15},
    {5'd4,  8'h7F, 7'h00, 7'h33, 7'h15},
    {5'd28, 8'h09, 7'h00, 7'h33, 7'h15},
    {5'd4,  8'h44, 7'h44, 7'h33, 7'h15},
    {5'd28, 8'h00, 7'h44, 7'h33, 7'h15}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code", code_out, 0);
    chk("R1 turbo", turbo_out, 0);
    chk("R1 pwr", pwr_mode, 0);
    chk("R1 operating", operating, 1);
    rd(5'd0, rv);  chk("R1 reg0", rv, 8'h20);
    rd(5'd10, rv); chk("R1 reg10", rv, 8'h04);
    rd(5'd11, rv); chk("R1 reg11", rv, 8'h44);
    rd(5'd31, rv); chk("R1 reg31", rv, 8'h17);
    rd(5'd28, rv); chk("R1 reg28", rv, 8'h00);

    // R2 R3 R4 R5: staged writes, trigger fire, remap, mask and bypass
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][33:29], VEC[k][28:21]);
      chk($sformatf("R2/R3/R4/R5 vector %0d", k), code_out, VEC[k][20:0]);
    end
    rd(5'd4, rv); chk("R2 shadow readback", rv, 8'h44);

    // R12 trigger bits self-clear, unimplemented addresses
    wr(5'd28, 8'h07);
    rd(5'd28, rv); chk("R12 trig readback", rv, 8'h00);
    wr(5'd12, 8'hFF);
    rd(5'd12, rv); chk("R12 unimpl read", rv, 8'h00);
    chk("R12 unimpl write no effect", code_out, {7'h44, 7'h33, 7'h15});
    // R11 identity and id nibble
    wr(5'd29, 8'hFF);
    rd(5'd29, rv); chk("R11 reg29", rv, 8'h05);
    rd(5'd30, rv); chk("R11 reg30", rv, 8'h04);
    wr(5'd31, 8'h3A);
    rd(5'd31, rv); chk("R11 reg31", rv, 8'h1A);

    // R6 second bank and swap strobe
    wr(5'd6, 8'h81); wr(5'd7, 8'h02); wr(5'd8, 8'h03);
    wr(5'd28, 8'h07);
    chk("R6 bank0 still drives", code_out, {7'h44, 7'h33, 7'h15});
    @(negedge clk); gpio = 1'b1;
    @(posedge clk); #1;
    chk("R6 swap strobe", bank_swap, 1);
    chk("R6 bank1 codes", code_out, {7'h03, 7'h02, 7'h01});
    chk("R6 bank1 turbo", turbo_out, 3'b001);
    @(posedge clk); #1;
    chk("R6 strobe one cycle", bank_swap, 0);
    @(negedge clk); gpio = 1'b0;
    @(posedge clk); #1;
    chk("R6 back to bank0", code_out, {7'h44, 7'h33, 7'h15});

    // R7 glide fields
    wr(5'd1, 8'hA5);
    chk("R7 staged step", step_delay, 5'h00);
    wr(5'd28, 8'h01);
    chk("R7 step delay", step_delay, 5'h14);
    chk("R7 glide enables", glide_en, 3'b101);

    // R10 power mode
    wr(5'd28, 8'h80);
    chk("R10 low power", pwr_mode, 2'b10);
    wr(5'd28, 8'hC0);
    chk("R10 unused ignored", pwr_mode, 2'b10);
    wr(5'd28, 8'h88);
    wr(5'd0, 8'h00);
    chk("R10 reg0 pwr", pwr_mode, 2'b00);
    chk("R10 idle", operating, 0);
    wr(5'd0, 8'h20);
    chk("R10 operating", operating, 1);

    // R8 soft reset
    wr(5'd28, 8'h88);
    wr(5'd2, 8'h11);
    chk("R4 bypass A", code_out[6:0], 7'h11);
    wr(5'd26, 8'h80);
    chk("R8 code cleared", code_out, 0);
    chk("R8 glide cleared", step_delay, 0);
    rd(5'd28, rv); chk("R8 reg28 kept", rv, 8'h88);
    rd(5'd31, rv); chk("R8 reg31 kept", rv, 8'h1A);
    rd(5'd10, rv); chk("R8 reg10 default", rv, 8'h04);

    // R9 mode reset through reg28 and reg0
    wr(5'd28, 8'h40);
    rd(5'd28, rv); chk("R9 reg28 default", rv, 8'h00);
    rd(5'd31, rv); chk("R9 reg31 default", rv, 8'h17);
    wr(5'd31, 8'h35);
    wr(5'd28, 8'h08);
    wr(5'd2, 8'h22);
    chk("R9 pre A", code_out[6:0], 7'h22);
    wr(5'd0, 8'h40);
    chk("R9 reg0 reset code", code_out, 0);
    rd(5'd31, rv); chk("R9 reg0 reset id", rv, 8'h17);

    // R5 select 11 joins no trigger and no mask
    wr(5'd9, 8'hC0);
    wr(5'd28, 8'h01);
    wr(5'd2, 8'h55);
    wr(5'd28, 8'h07);
    chk("R5 sel11 no fire", code_out[6:0], 7'h00);
    wr(5'd28, 8'h38);
    wr(5'd2, 8'h56);
    chk("R5 sel11 no bypass", code_out[6:0], 7'h00);
    rd(5'd2, rv); chk("R5 shadow kept", rv, 8'h56);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule